// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns the bus clock into serial clock timing for an SPI master. A single 8-bit configuration register holds two 3-bit fields: a linear prescale `pre` and a power-of-two exponent `sel`. Together they give a divisor of (pre+1) x 2^(sel+1) bus clocks per serial clock period. Each serial clock half-period therefore lasts (pre+1) x 2^sel bus clocks.

The shift engine requests a transfer with a one-cycle start pulse. The generator then produces exactly sixteen edge strobes, one for every 8-bit transfer. The strobes alternate between leading and trailing, and each one comes with the matching change in the serial clock level. Between transfers the counter is held cleared and the clock rests at its idle polarity. The divisor and the polarity are captured when the transfer starts, so a register write made during a transfer only takes effect on the next one.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset the register reads 0x00, `busy_o` is 0, neither strobe is asserted, and `sck_o` equals the idle polarity.
- R2: Register bits 7 and 3 always read 0. Bits 6:4 store `pre` and bits 2:0 store `sel`, so writing 0xFF reads back 0x77.
- R3: Strobe j of a transfer (j = 0..15) is asserted in bus cycle (j+1) x H - 1, counted from the first busy cycle, where H = (pre+1) x 2^sel. No other busy cycle carries a strobe. Register 0x00 gives H=1, 0x10 gives H=2 (divisor 4), 0x21 gives H=6 (divisor 12), and 0x77 gives H=1024 (divisor 2048).
- R4: Each transfer produces exactly 16 strobes. Even-numbered strobes are leading strobes (`lead_o`), odd-numbered strobes are trailing strobes (`trail_o`), and the two are never asserted together.
- R5: While idle, `sck_o` equals the polarity input and no strobe is asserted. During a transfer, `sck_o` changes in the cycle after each strobe and stays constant otherwise.
- R6: The divisor and the polarity are captured at the start of a transfer. A register write during a transfer does not change that transfer's timing, but it is visible on `cfg_o`.
- R7: A start pulse that arrives while `busy_o` is 1 is ignored.
- R8: `busy_o` stays high for exactly 16 x H bus cycles after an accepted start, and then returns low with `sck_o` back at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_o | output | 8 | Configuration register contents |
| cpol_i | input | 1 | Idle level of the serial clock |
| xfer_start_i | input | 1 | One-cycle transfer request |
| busy_o | output | 1 | Transfer in progress |
| lead_o | output | 1 | Leading edge strobe |
| trail_o | output | 1 | Trailing edge strobe |
| sck_o | output | 1 | Serial clock level |

## Verification
The bench measures the cycle position of every strobe against H at both extremes. At H=1 a strobe is due in every cycle, and an off-by-one counter would skip some of them or double the period. At H=1024 a truncated shift or a narrow counter would wrap early. Transfers with high idle polarity show whether a design leaves the clock at the wrong idle level or ends with an odd number of toggles. A register write and a second start pulse in the middle of a transfer catch a design that reloads its divisor from the live register or restarts the strobe count, which would shift every later strobe.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int PRE_W  = 3;
  localparam int SEL_W  = 3;
  localparam int CFG_W  = PRE_W + SEL_W + 2;
  localparam int HALF_W = PRE_W + 1 + (2 ** SEL_W) - 1;

  typedef struct packed {
    logic             rsv_hi;
    logic [PRE_W-1:0] pre;
    logic             rsv_lo;
    logic [SEL_W-1:0] sel;
  } cfg_t;

  function automatic logic [HALF_W-1:0] half_of(cfg_t c);
    logic [HALF_W-1:0] p;
    p = HALF_W'(c.pre) + HALF_W'(1);
    return p << c.sel;
  endfunction
endpackage

// File: rtl/spi_baud_reg.sv
module spi_baud_reg
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t d;
  cfg_t q;

  always_comb begin
    d        = cfg_t'(wdata_i);
    d.rsv_hi = 1'b0;
    d.rsv_lo = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d;
  end

  assign cfg_o = q;

  // R2
  a_r2_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_o.rsv_hi == 1'b0 && cfg_o.rsv_lo == 1'b0));
endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div
  import spi_baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [HALF_W-1:0] half_q_o,
  output logic              strobe_o
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;

  assign strobe_o = run_i && (cnt_q == half_q - HALF_W'(1));
  assign half_q_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
    end else if (start_i) begin
      half_q <= half_i;
      cnt_q  <= '0;
    end else if (!run_i || strobe_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + HALF_W'(1);
    end
  end

  // R6: divisor frozen during a transfer
  a_r6_half_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(half_q));
endmodule

// File: rtl/spi_baud_edge.sv
module spi_baud_edge #(
  parameter int EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic strobe_i,
  input  logic cpol_i,
  output logic busy_o,
  output logic lead_o,
  output logic trail_o,
  output logic sck_o
);
  localparam int EW = $clog2(EDGES);

  logic [EW-1:0] edge_q;
  logic          busy_q, sck_q, cpol_q, seen_lead_q;

  assign lead_o  = strobe_i && !edge_q[0];
  assign trail_o = strobe_i &&  edge_q[0];
  assign busy_o  = busy_q;
  assign sck_o   = sck_q ^ cpol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      cpol_q <= 1'b0;
    end else begin
      if (!busy_q) cpol_q <= cpol_i;
      if (start_i) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sck_q  <= 1'b0;
      end else if (strobe_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EW'(1);
        if (edge_q == EW'(EDGES - 1)) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_lead_q <= 1'b0;
    else if (lead_o)  seen_lead_q <= 1'b1;
    else if (trail_o) seen_lead_q <= 1'b0;
  end

  // R4
  a_r4_lead_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> !seen_lead_q);
  a_r4_trail_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> seen_lead_q);
  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));
  // R5
  a_r5_sck_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |=> sck_o != $past(sck_o));
  a_r5_sck_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !strobe_i && !start_i) |=> $stable(sck_o));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  input  logic             cpol_i,
  input  logic             xfer_start_i,
  output logic             busy_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             sck_o
);
  localparam int EDGES = 2 * NBITS;
  localparam int TOT_W = HALF_W + $clog2(EDGES) + 1;

  cfg_t              cfg_q;
  logic              accept, strobe, busy;
  logic [HALF_W-1:0] half_q;

  assign accept = xfer_start_i && !busy;
  assign busy_o = busy;
  assign cfg_o  = cfg_q;

  spi_baud_reg u_reg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg_q)
  );

  spi_baud_div u_div (
    .clk_i, .rst_ni, .start_i(accept), .run_i(busy),
    .half_i(half_of(cfg_q)), .half_q_o(half_q), .strobe_o(strobe)
  );

  spi_baud_edge #(.EDGES(EDGES)) u_edge (
    .clk_i, .rst_ni, .start_i(accept), .strobe_i(strobe), .cpol_i,
    .busy_o(busy), .lead_o, .trail_o, .sck_o
  );

  // checker: busy cycles per transfer
  logic [TOT_W-1:0] tot_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tot_q <= '0;
    else if (accept) tot_q <= '0;
    else if (busy)   tot_q <= tot_q + TOT_W'(1);
  end

  // R8
  a_r8_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> tot_q == TOT_W'(EDGES) * TOT_W'(half_q));
  a_r8_ends_trail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(trail_o));
  // R7
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && xfer_start_i && !trail_o) |=> busy_o);
  // R5
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(lead_o || trail_o));
endmodule

// File: tb/sim_spi_baud_gen.sv
`timescale 1ns/1ps
module sim_spi_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] cfg;
  logic       cpol = 1'b0;
  logic       start = 1'b0;
  logic       busy, lead, trail, sck;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  spi_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_o(cfg), .cpol_i(cpol), .xfer_start_i(start), .busy_o(busy),
    .lead_o(lead), .trail_o(trail), .sck_o(sck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  // one transfer; disturb writes 0x77 and pulses start mid-transfer
  task automatic xfer(input logic [7:0] v, input bit pol, input bit disturb);
    int h, n_str, e_pos, e_alt, e_sck, e_busy, lvl;
    h = (int'(v[6:4]) + 1) << v[2:0];
    n_str = 0; e_pos = 0; e_alt = 0; e_sck = 0; e_busy = 0;
    cpol = pol;
    wr(v);
    @(negedge clk);
    check(sck == pol && !busy, "R5 idle level", sck, pol);
    start = 1'b1;
    for (int k = 0; k <= 16 * h; k++) begin
      bit exp_str, exp_lead;
      @(negedge clk);
      exp_str  = (k < 16 * h) && ((k + 1) % h == 0);
      exp_lead = exp_str && ((((k + 1) / h) - 1) % 2 == 0);
      lvl = pol ^ (n_str % 2);
      if (sck != lvl) e_sck++;
      if (busy != (k < 16 * h)) e_busy++;
      if ((lead || trail) != exp_str) e_pos++;
      if (lead != exp_lead || (lead && trail)) e_alt++;
      if (lead || trail) n_str++;
      start = 1'b0;
      if (disturb && k == 2) begin we = 1'b1; wdata = 8'h77; start = 1'b1; end
      if (k == 3) we = 1'b0;
    end
    check(e_pos == 0, "R3 strobe positions", e_pos, 0);
    check(n_str == 16, "R4 strobe count", n_str, 16);
    check(e_alt == 0, "R4 lead/trail order", e_alt, 0);
    check(e_sck == 0, "R5 sck level", e_sck, 0);
    check(e_busy == 0 && sck == pol, "R8 busy length", e_busy, 0);
  endtask

  task automatic t_reset;
    check(cfg == 8'h00, "R1 cfg reset", cfg, 0);
    check(!busy && !lead && !trail, "R1 idle outputs", busy, 0);
    check(sck == 1'b0, "R1 sck idle", sck, 0);
  endtask

  task automatic t_reg;
    wr(8'hFF);
    @(negedge clk);
    check(cfg == 8'h77, "R2 reserved bits", cfg, 8'h77);
    wr(8'h5A);
    @(negedge clk);
    check(cfg == 8'h52, "R2 field positions", cfg, 8'h52);
  endtask

  task automatic t_disturb;
    xfer(8'h10, 1'b0, 1'b1);
    check(cfg == 8'h77, "R6 write visible", cfg, 8'h77);
    @(negedge clk);
    check(!busy, "R7 start ignored", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg();
    xfer(8'h00, 1'b0, 1'b0);
    xfer(8'h10, 1'b0, 1'b0);
    xfer(8'h21, 1'b0, 1'b0);
    xfer(8'h03, 1'b1, 1'b0);
    t_disturb();
    xfer(8'h77, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule